// File: doc/BRIEF.md
# Memory Error Capture Registers

This block sits beside the ECC check logic of a memory controller and keeps a record of the first correctable (single-bit) and the first uncorrectable (multi-bit) error seen. The ECC datapath reports each error as a one-cycle valid strobe. With the strobe it gives the 4 KB page number of the failing access and the memory row it hit. There is a separate strobe, page and row for each error class.

Three registers are reachable through a plain select/write/read port. The capture-address register holds the page of the logged error in bits 31:12, with a flag for each error class in its low bits. The row-status register holds a flag and the captured row number for each class. The control register enables a system-error pulse per class. Each flag is cleared by writing 1 to it. Once a flag is set, it blocks any later capture of the same class, so software always sees the first event until it acknowledges it. No syndrome is kept, and addresses are logged at 4 KB granularity only.

Top module: `mem_err_capture`

## Requirements
- R1: While rst_n is low at a clock edge, every flag, row, page and control bit becomes zero, and serr_pulse is low in the following cycle.
- R2: A single-bit strobe in a cycle where the status single-bit flag is clear sets that flag (status bit 0) and stores sb_row in status bits 3:1.
- R3: A multi-bit strobe in a cycle where the status multi-bit flag is clear sets that flag (status bit 4) and stores mb_row in status bits 7:5.
- R4: Reading the capture-address register (reg_sel 0) returns the logged page in bits 31:12, zeros in bits 11:2, the multi-bit flag in bit 1 and the single-bit flag in bit 0. The status register is reg_sel 1.
- R5: While a flag is set, further strobes of its class change neither that flag nor its row, and they change no logged page.
- R6: A write of 1 to a flag bit clears it (address register bits 0 and 1, status register bits 0 and 4). A write of 0 leaves it set, and writes never alter pages or rows.
- R7: A multi-bit capture always loads the page from mb_page, and it wins when both classes are captured in the same cycle. A single-bit capture loads sb_page only while the address multi-bit flag is clear.
- R8: The control register (reg_sel 2) stores all 8 written bits and reads them back. Bit 0 enables the pulse for single-bit errors and bit 1 enables it for multi-bit errors. reg_sel 3 reads zero.
- R9: serr_pulse is high for exactly the one cycle after a status flag is newly captured whose class is enabled, and stays low for disabled classes.
- R10: If a strobe and a write-1 to its flag arrive in the same cycle, a set flag ends clear and the strobe is lost. A clear flag ends set with the new row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sb_valid | input | 1 | Single-bit error strobe |
| sb_page | input | 20 | 4 KB page number of the single-bit error |
| sb_row | input | 3 | Memory row of the single-bit error |
| mb_valid | input | 1 | Multi-bit error strobe |
| mb_page | input | 20 | 4 KB page number of the multi-bit error |
| mb_row | input | 3 | Memory row of the multi-bit error |
| reg_sel | input | 2 | Register select: 0 address, 1 status, 2 control, 3 none |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| serr_pulse | output | 1 | One-cycle system-error indication |

## Verification
The hardest states to reach are those where the address and status flags disagree, because each register is cleared on its own. One example is a single-bit strobe that arrives after the multi-bit page has been logged and only the single-bit flags have been acknowledged. The other is a strobe that lands in the same cycle as its own write-1 acknowledge. The stimulus reaches these states by clearing just one flag and then firing a strobe. In the second case it drives the acknowledge and the strobe in the same cycle, once with the flag set and once with it clear. A behavioural model compares every register read and the pulse on each cycle.

// File: rtl/mec_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the memory error capture block: register
// selection codes and error class indices.
package mec_pkg;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_STS  = 2'd1,
        SEL_CMD  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam int CLS_SB  = 0;
    localparam int CLS_MB  = 1;
    localparam int NUM_CLS = 2;

endpackage

// File: rtl/mec_flag_slot.sv
`timescale 1ns/1ps
// First-event capture slot: a sticky flag with a payload stored when the
// flag is taken. Assumes evt is a one-cycle strobe; clr is write-1-to-clear.
// A strobe is ignored while the flag is set, so the first payload survives.
module mec_flag_slot #(
    parameter int PAY_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic [PAY_W-1:0] evt_pay,
    input  logic             clr,
    output logic             flag,
    output logic [PAY_W-1:0] pay,
    output logic             take
);

    // A capture happens only into an empty slot.
    assign take = evt & ~flag;

    // Flag and payload register: capture has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
            pay  <= '0;
        end else if (take) begin
            flag <= 1'b1;
            pay  <= evt_pay;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/mec_addr_log.sv
`timescale 1ns/1ps
// Capture-address logger: one sticky flag per error class and one shared
// page field. Assumes single-cycle strobes. A multi-bit capture always loads
// the page; a single-bit capture loads it only when no multi-bit page is held.
module mec_addr_log #(
    parameter int PAGE_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sb_valid,
    input  logic [PAGE_W-1:0] sb_page,
    input  logic              mb_valid,
    input  logic [PAGE_W-1:0] mb_page,
    input  logic [1:0]        clr,
    output logic [1:0]        flag,
    output logic [PAGE_W-1:0] page
);

    import mec_pkg::*;

    logic [1:0] take;

    // New captures per class, blocked by the class's own flag.
    always_comb begin
        take[CLS_SB] = sb_valid & ~flag[CLS_SB];
        take[CLS_MB] = mb_valid & ~flag[CLS_MB];
    end

    for (genvar g = 0; g < NUM_CLS; g++) begin : g_flag
        // Sticky class flag: set on capture, else cleared by write-1.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag[g] <= 1'b0;
            else if (take[g])
                flag[g] <= 1'b1;
            else if (clr[g])
                flag[g] <= 1'b0;
        end
    end

    // Shared page field with multi-bit precedence.
    always_ff @(posedge clk) begin
        if (!rst_n)
            page <= '0;
        else if (take[CLS_MB])
            page <= mb_page;
        else if (take[CLS_SB] && !flag[CLS_MB])
            page <= sb_page;
    end

endmodule

// File: rtl/mec_serr_gen.sv
`timescale 1ns/1ps
// System-error pulse generator: registers a one-cycle pulse when any
// enabled error class is newly captured. Assumes take inputs are single
// cycle per capture (guaranteed by the sticky flags upstream).
module mec_serr_gen (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] take,
    input  logic [1:0] enable,
    output logic       serr
);

    // Pulse register: high for the cycle after an enabled capture.
    always_ff @(posedge clk) begin
        if (!rst_n)
            serr <= 1'b0;
        else
            serr <= |(take & enable);
    end

endmodule

// File: rtl/mem_err_capture.sv
`timescale 1ns/1ps
// Memory error capture register set. Logs the first single-bit and first
// multi-bit ECC error (page at 4 KB granularity and row), exposes an
// address, a status and a control register on a select/write/read port,
// and pulses a system-error output for enabled classes.
// Assumes the ECC datapath gives one-cycle strobes with page and row valid.
module mem_err_capture #(
    parameter int ADDR_W   = 32,
    parameter int PAGE_LSB = 12,
    parameter int ROW_W    = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sb_valid,
    input  logic [ADDR_W-PAGE_LSB-1:0]   sb_page,
    input  logic [ROW_W-1:0]             sb_row,
    input  logic                         mb_valid,
    input  logic [ADDR_W-PAGE_LSB-1:0]   mb_page,
    input  logic [ROW_W-1:0]             mb_row,
    input  logic [1:0]                   reg_sel,
    input  logic                         reg_wr,
    input  logic [2*ROW_W+1:0]           reg_wdata,
    output logic [ADDR_W-1:0]            reg_rdata,
    output logic                         serr_pulse
);

    import mec_pkg::*;

    localparam int PAGE_W      = ADDR_W - PAGE_LSB;
    localparam int STS_W       = 2 * ROW_W + 2;
    localparam int MB_FLAG_BIT = ROW_W + 1;

    reg_sel_e          sel;
    logic              wr_addr, wr_sts, wr_cmd;
    logic [1:0]        clr_addr, clr_sts;
    logic [1:0]        evt_v;
    logic [ROW_W-1:0]  evt_row [NUM_CLS];
    logic [1:0]        sts_flag, sts_take;
    logic [ROW_W-1:0]  sts_row [NUM_CLS];
    logic [1:0]        addr_flag;
    logic [PAGE_W-1:0] addr_page;
    logic [STS_W-1:0]  cmd_q;

    assign sel = reg_sel_e'(reg_sel);

    // Write decode and write-1-to-clear masks per register.
    always_comb begin
        wr_addr           = reg_wr && (sel == SEL_ADDR);
        wr_sts            = reg_wr && (sel == SEL_STS);
        wr_cmd            = reg_wr && (sel == SEL_CMD);
        clr_addr[CLS_SB]  = wr_addr & reg_wdata[0];
        clr_addr[CLS_MB]  = wr_addr & reg_wdata[1];
        clr_sts[CLS_SB]   = wr_sts & reg_wdata[0];
        clr_sts[CLS_MB]   = wr_sts & reg_wdata[MB_FLAG_BIT];
    end

    // Gather per-class event inputs into indexed form.
    always_comb begin
        evt_v[CLS_SB]   = sb_valid;
        evt_v[CLS_MB]   = mb_valid;
        evt_row[CLS_SB] = sb_row;
        evt_row[CLS_MB] = mb_row;
    end

    for (genvar g = 0; g < NUM_CLS; g++) begin : g_sts
        mec_flag_slot #(
            .PAY_W (ROW_W)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt     (evt_v[g]),
            .evt_pay (evt_row[g]),
            .clr     (clr_sts[g]),
            .flag    (sts_flag[g]),
            .pay     (sts_row[g]),
            .take    (sts_take[g])
        );
    end

    mec_addr_log #(
        .PAGE_W (PAGE_W)
    ) u_addr_log (
        .clk      (clk),
        .rst_n    (rst_n),
        .sb_valid (sb_valid),
        .sb_page  (sb_page),
        .mb_valid (mb_valid),
        .mb_page  (mb_page),
        .clr      (clr_addr),
        .flag     (addr_flag),
        .page     (addr_page)
    );

    // Control register: fully writable, low two bits enable the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_q <= '0;
        else if (wr_cmd)
            cmd_q <= reg_wdata;
    end

    mec_serr_gen u_serr (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (sts_take),
        .enable (cmd_q[1:0]),
        .serr   (serr_pulse)
    );

    // Read multiplexer for the selected register.
    always_comb begin
        unique case (sel)
            SEL_ADDR: reg_rdata = {addr_page, {(PAGE_LSB-2){1'b0}},
                                   addr_flag[CLS_MB], addr_flag[CLS_SB]};
            SEL_STS:  reg_rdata = {{(ADDR_W-STS_W){1'b0}},
                                   sts_row[CLS_MB], sts_flag[CLS_MB],
                                   sts_row[CLS_SB], sts_flag[CLS_SB]};
            SEL_CMD:  reg_rdata = {{(ADDR_W-STS_W){1'b0}}, cmd_q};
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mec_capture_chk.sv
`timescale 1ns/1ps
// Property checker for mem_err_capture, attached by bind. Observes the
// strobes, the flags and fields held by the capture logic, and the pulse.
module mec_capture_chk #(
    parameter int PAGE_W = 20,
    parameter int ROW_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sb_valid,
    input logic              mb_valid,
    input logic [PAGE_W-1:0] mb_page,
    input logic [1:0]        sts_flag,
    input logic [ROW_W-1:0]  mb_row_q,
    input logic [1:0]        addr_flag,
    input logic [PAGE_W-1:0] addr_page,
    input logic              serr
);

    // R2: a single-bit strobe on a clear status flag sets it.
    a_r2_sb_take: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_valid && !sts_flag[0]) |=> sts_flag[0]);

    // R5: a held multi-bit row does not move while its flag is set.
    a_r5_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
        sts_flag[1] |=> $stable(mb_row_q));

    // R7: a multi-bit capture loads the strobe's page.
    a_r7_mb_page: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_valid && !addr_flag[1]) |=> (addr_page == $past(mb_page)));

    // R6: the address single-bit flag only rises on a strobe.
    a_r6_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_flag[0]) |-> $past(sb_valid));

    // R9: a pulse always follows a strobe.
    a_r9_serr_cause: assert property (@(posedge clk) disable iff (!rst_n)
        serr |-> $past(sb_valid || mb_valid));

endmodule

bind mem_err_capture mec_capture_chk #(
    .PAGE_W (ADDR_W - PAGE_LSB),
    .ROW_W  (ROW_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sb_valid  (sb_valid),
    .mb_valid  (mb_valid),
    .mb_page   (mb_page),
    .sts_flag  (sts_flag),
    .mb_row_q  (sts_row[1]),
    .addr_flag (addr_flag),
    .addr_page (addr_page),
    .serr      (serr_pulse)
);

// File: tb/mem_err_capture_tb.sv
`timescale 1ns/1ps
// Self-checking bench: behavioural model compared every cycle, plus
// directed checks against hand-computed register values.
module mem_err_capture_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sb_valid = 1'b0, mb_valid = 1'b0;
    logic [19:0] sb_page = '0, mb_page = '0;
    logic [2:0]  sb_row = '0, mb_row = '0;
    logic [1:0]  reg_sel = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        serr_pulse;

    int checks = 0;
    int fails  = 0;
    string tag = "R1";

    // model state
    logic [19:0] m_page = '0;
    logic        m_asb = 0, m_amb = 0, m_ssb = 0, m_smb = 0, m_serr = 0;
    logic [2:0]  m_rsb = '0, m_rmb = '0;
    logic [7:0]  m_cmd = '0;

    mem_err_capture u_dut (
        .clk(clk), .rst_n(rst_n),
        .sb_valid(sb_valid), .sb_page(sb_page), .sb_row(sb_row),
        .mb_valid(mb_valid), .mb_page(mb_page), .mb_row(mb_row),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .serr_pulse(serr_pulse)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] model_read(input logic [1:0] s);
        case (s)
            2'd0:    return {m_page, 10'd0, m_amb, m_asb};
            2'd1:    return {24'd0, m_rmb, m_smb, m_rsb, m_ssb};
            2'd2:    return {24'd0, m_cmd};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", t, act, exp);
        end
    endtask

    task automatic model_update();
        bit ts_sb, ts_mb, ta_sb, ta_mb, wa, ws, wc;
        if (!rst_n) begin
            m_page = '0; m_asb = 0; m_amb = 0; m_ssb = 0; m_smb = 0;
            m_rsb = '0; m_rmb = '0; m_cmd = '0; m_serr = 0;
            return;
        end
        ts_sb = sb_valid && !m_ssb;  ts_mb = mb_valid && !m_smb;
        ta_sb = sb_valid && !m_asb;  ta_mb = mb_valid && !m_amb;
        wa = reg_wr && reg_sel == 2'd0;
        ws = reg_wr && reg_sel == 2'd1;
        wc = reg_wr && reg_sel == 2'd2;
        m_serr = (m_cmd[0] && ts_sb) || (m_cmd[1] && ts_mb);
        if (ta_mb) m_page = mb_page;
        else if (ta_sb && !m_amb) m_page = sb_page;
        m_asb = ta_sb ? 1'b1 : (m_asb && !(wa && reg_wdata[0]));
        m_amb = ta_mb ? 1'b1 : (m_amb && !(wa && reg_wdata[1]));
        if (ts_sb) m_rsb = sb_row;
        if (ts_mb) m_rmb = mb_row;
        m_ssb = ts_sb ? 1'b1 : (m_ssb && !(ws && reg_wdata[0]));
        m_smb = ts_mb ? 1'b1 : (m_smb && !(ws && reg_wdata[4]));
        if (wc) m_cmd = reg_wdata;
    endtask

    // One clock: compare against the model, advance at the edge.
    task automatic step();
        #2;
        check({tag, " rdata"}, reg_rdata, model_read(reg_sel));
        check({tag, " serr"}, {31'd0, serr_pulse}, {31'd0, m_serr});
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic idle();
        sb_valid = 0; mb_valid = 0; reg_wr = 0; reg_wdata = '0;
    endtask

    task automatic do_evt(input bit sv, input logic [19:0] sp, input logic [2:0] sr,
                          input bit mv, input logic [19:0] mp, input logic [2:0] mr);
        sb_valid = sv; sb_page = sp; sb_row = sr;
        mb_valid = mv; mb_page = mp; mb_row = mr;
        step(); idle();
    endtask

    task automatic do_wr(input logic [1:0] s, input logic [7:0] d);
        reg_sel = s; reg_wr = 1; reg_wdata = d;
        step(); idle();
    endtask

    task automatic expect_reg(input logic [1:0] s, input logic [31:0] exp, input string t);
        reg_sel = s; #1;
        check({t, " directed"}, reg_rdata, exp);
    endtask

    task automatic expect_serr(input bit exp, input string t);
        #1;
        check({t, " pulse"}, {31'd0, serr_pulse}, {31'd0, exp});
    endtask

    initial begin : watchdog
        #(20 * 200000);
        fails++; checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        tag = "R1";
        repeat (3) step();
        rst_n = 1;
        expect_reg(2'd0, 32'h0, "R1");
        expect_reg(2'd1, 32'h0, "R1");
        expect_reg(2'd2, 32'h0, "R1");
        expect_serr(0, "R1");

        tag = "R8";
        do_wr(2'd2, 8'hA3);
        expect_reg(2'd2, 32'hA3, "R8");
        expect_reg(2'd3, 32'h0, "R8");

        tag = "R2";
        do_evt(1, 20'h12345, 3'd5, 0, 20'h0, 3'd0);
        expect_serr(1, "R9");
        expect_reg(2'd1, 32'h0B, "R2");
        expect_reg(2'd0, 32'h12345001, "R4");
        step();
        expect_serr(0, "R9");

        tag = "R5";
        do_evt(1, 20'h0ABCD, 3'd2, 0, 20'h0, 3'd0);
        expect_serr(0, "R5");
        expect_reg(2'd1, 32'h0B, "R5");
        expect_reg(2'd0, 32'h12345001, "R5");

        tag = "R3";
        do_evt(0, 20'h0, 3'd0, 1, 20'h54321, 3'd6);
        expect_serr(1, "R9");
        expect_reg(2'd1, 32'hDB, "R3");
        expect_reg(2'd0, 32'h54321003, "R7");

        tag = "R6";
        do_wr(2'd0, 8'h00);
        do_wr(2'd1, 8'h00);
        expect_reg(2'd0, 32'h54321003, "R6");
        expect_reg(2'd1, 32'hDB, "R6");
        do_wr(2'd0, 8'h01);
        do_wr(2'd1, 8'h01);
        expect_reg(2'd0, 32'h54321002, "R6");
        expect_reg(2'd1, 32'hDA, "R6");

        tag = "R7";
        do_evt(1, 20'h11111, 3'd1, 0, 20'h0, 3'd0);
        expect_reg(2'd0, 32'h54321003, "R7");
        expect_reg(2'd1, 32'hD3, "R7");
        do_wr(2'd0, 8'h03);
        do_wr(2'd1, 8'h11);
        expect_reg(2'd0, 32'h54321000, "R6");
        expect_reg(2'd1, 32'hC2, "R6");
        do_evt(1, 20'h0AAAA, 3'd3, 1, 20'h0BBBB, 3'd4);
        expect_reg(2'd0, 32'h0BBBB003, "R7");
        expect_reg(2'd1, 32'h97, "R7");

        tag = "R10";
        reg_sel = 2'd1; reg_wr = 1; reg_wdata = 8'h01;
        sb_valid = 1; sb_page = 20'h22222; sb_row = 3'd7;
        step(); idle();
        expect_serr(0, "R10");
        expect_reg(2'd1, 32'h96, "R10");
        reg_sel = 2'd1; reg_wr = 1; reg_wdata = 8'h01;
        sb_valid = 1; sb_page = 20'h22222; sb_row = 3'd7;
        step(); idle();
        expect_serr(1, "R10");
        expect_reg(2'd1, 32'h9F, "R10");

        tag = "R9";
        do_wr(2'd2, 8'h00);
        do_wr(2'd1, 8'h11);
        do_evt(1, 20'h3, 3'd1, 1, 20'h4, 3'd2);
        expect_serr(0, "R9");
        step();
        expect_serr(0, "R9");
        do_wr(2'd2, 8'h02);
        do_wr(2'd1, 8'h10);
        do_evt(0, 20'h0, 3'd0, 1, 20'h5, 3'd3);
        expect_serr(1, "R9");

        tag = "R1";
        rst_n = 0;
        step();
        rst_n = 1;
        expect_reg(2'd0, 32'h0, "R1");
        expect_reg(2'd1, 32'h0, "R1");
        expect_reg(2'd2, 32'h0, "R1");
        expect_serr(0, "R1");
        step();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule